// File: doc/BRIEF.md
# Smart card character serial interface

This block moves single 8-bit characters over a half-duplex smart card data line. It divides the module clock down to a card clock and times every bit as 372 periods of that card clock. Each character is a low start bit, eight data bits and a parity bit. The transmitter then holds the line high for one more bit time before it reports idle.

Three independent control inputs select the bit order, whether the eight data levels are inverted, and whether parity is odd. Setting all three gives the inverse convention. Clearing all three gives the direct convention. The receiver de-inverts and re-orders what it samples, returns the byte with a parity-error flag, and recognises the two initial characters that announce each convention.

The divider value and the prescale select are taken into use only while no character is being sent or received.

Top module: `cardCharLink`

## Requirements
- R1: While `clkOutEn` is 1, `cardClk` is a square wave whose period is 2·4^preSel·(divN+1) module clocks. While `clkOutEn` is 0, `cardClk` stays low.
- R2: A change of `divN` or `preSel` made while a character is in progress leaves the card clock period unchanged. The new value takes effect once the transmitter and the receiver are both idle.
- R3: A transmit request is accepted when `txValid` is 1 and neither direction is busy. The line then carries 11 slots of 372 card clock periods each: start low, eight data slots, parity, and a high guard slot. `txBusy` is 1 from the accepting edge until the guard slot ends.
- R4: With `msbFirst`=0 and `invertData`=0, data slot i (i=0..7) carries byte bit i, and a 1 is sent high.
- R5: `msbFirst`=1 makes data slot i carry byte bit 7−i. `invertData`=1 inverts the level of every data slot. The two controls act independently.
- R6: The parity slot level is the XOR of the eight byte bits, XORed with `oddParity`. `invertData` never changes the parity slot.
- R7: The receiver detects a falling edge on `dataIn`, samples each slot near its middle, and pulses `rxValid` for one cycle during the parity slot. `rxByte` then holds the byte recovered with the current order and inversion controls.
- R8: `rxParityErr` is 1 exactly when the sampled parity slot differs from the XOR of the recovered byte bits, XORed with `oddParity`.
- R9: A low pulse that ends before the middle of the start slot produces no `rxValid`. The next genuine character is still received correctly.
- R10: The receiver compares the raw levels of the eight received data slots, in arrival order with the first slot as bit 0, against two patterns. The pattern 0x3B sets `convValid`=1 and `convInverse`=0, which is the direct initial character 0x3B. The pattern 0x03 sets `convValid`=1 and `convInverse`=1, which is 0x3F sent MSB first with inverted data. Both flags are 0 after reset and do not change on any other character.
- R11: A request made while `txBusy` is 1 is ignored: the frame in flight is unchanged and no second frame follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Active-low asynchronous reset |
| divN | input | 8 | Card clock divider value N |
| preSel | input | 2 | Prescale select n (factor 4^n) |
| clkOutEn | input | 1 | Drive the card clock pin |
| msbFirst | input | 1 | Data bit order, 1 = MSB first |
| invertData | input | 1 | Invert the eight data levels |
| oddParity | input | 1 | 1 = odd parity, 0 = even |
| txByte | input | 8 | Byte to send |
| txValid | input | 1 | Transmit request |
| txBusy | output | 1 | A transmit frame is in progress |
| rxByte | output | 8 | Last received byte |
| rxValid | output | 1 | One-cycle pulse: new received byte |
| rxParityErr | output | 1 | Parity error of the last received byte |
| cardClk | output | 1 | Card clock pin |
| dataOut | output | 1 | Transmit line level (idle high) |
| dataIn | input | 1 | Receive line level |
| convValid | output | 1 | An initial character has been seen |
| convInverse | output | 1 | The seen initial character was inverse |

## Verification
All checks here use the fastest setting, N=0 and n=0. One card clock period is then two module clocks and one slot is 744. The transmit line changes on the edge that accepts the request, so slot k is sampled 372+744·k clocks after that edge, at the middle of the slot and well clear of both slot edges.

The receive path adds a two-stage synchroniser ahead of the falling-edge detector. `rxValid` is therefore due a few cycles after the middle of the parity slot. The bench requires that no pulse has arrived by the middle of data slot 8 and that exactly one has arrived by 400 clocks after the guard slot's middle, when `txBusy` must also have fallen.

Card clock periods are measured by counting falling module-clock edges between two rising card clock edges, after one full period has been discarded.

// File: rtl/cardLinkPkg.sv
package cardLinkPkg;
  localparam int DATA_W = 8;

  // strobes from control to datapath
  typedef struct packed {
    logic cfgLoad;
    logic txLoad;
    logic txShift;
    logic rxSample;
    logic rxDone;
  } linkStrobes_t;

  // raw line levels of the data slots, first slot in bit 0
  localparam logic [DATA_W-1:0] INIT_DIRECT_LINE  = 8'h3B;
  localparam logic [DATA_W-1:0] INIT_INVERSE_LINE = 8'h03;
endpackage

// File: rtl/cardLinkCtrl.sv
module cardLinkCtrl
  import cardLinkPkg::*;
#(
  parameter int ETU = 372
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         txValid,
  input  logic         cardRise,
  input  logic         rxLine,
  input  logic         rxFall,
  output linkStrobes_t strobes,
  output logic         txBusy
);
  localparam int CNT_W      = $clog2(ETU + 1);
  localparam int FRAME_BITS = DATA_W + 3;   // start, data, parity, guard
  localparam int RX_SLOTS   = DATA_W + 1;   // data and parity
  localparam int BIT_W      = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ETU - 1);
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(ETU / 2 - 1);
  localparam logic [BIT_W-1:0] TX_LAST  = BIT_W'(FRAME_BITS - 1);
  localparam logic [BIT_W-1:0] RX_LAST  = BIT_W'(RX_SLOTS);

  logic             txActive, rxActive;
  logic [CNT_W-1:0] txCnt, rxCnt;
  logic [BIT_W-1:0] txBit, rxBit;
  logic             txSlotEnd, rxSlotEnd;
  logic [CNT_W-1:0] rxTarget;

  always_comb begin
    txSlotEnd        = txActive && cardRise && (txCnt == LAST_CNT);
    rxTarget         = (rxBit == '0) ? HALF_CNT : LAST_CNT;
    rxSlotEnd        = rxActive && cardRise && (rxCnt == rxTarget);
    strobes.cfgLoad  = !txActive && !rxActive;
    strobes.txLoad   = !txActive && !rxActive && txValid;
    strobes.txShift  = txSlotEnd;
    strobes.rxSample = rxSlotEnd && (rxBit != '0);
    strobes.rxDone   = rxSlotEnd && (rxBit == RX_LAST);
  end

  assign txBusy = txActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txActive <= 1'b0;
      txCnt    <= '0;
      txBit    <= '0;
    end else if (strobes.txLoad) begin
      txActive <= 1'b1;
      txCnt    <= '0;
      txBit    <= '0;
    end else if (txActive && cardRise) begin
      if (txSlotEnd) begin
        txCnt <= '0;
        txBit <= txBit + 1'b1;
        if (txBit == TX_LAST) txActive <= 1'b0;
      end else begin
        txCnt <= txCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxActive <= 1'b0;
      rxCnt    <= '0;
      rxBit    <= '0;
    end else if (!rxActive && rxFall) begin
      rxActive <= 1'b1;
      rxCnt    <= '0;
      rxBit    <= '0;
    end else if (rxActive && cardRise) begin
      if (rxSlotEnd) begin
        rxCnt <= '0;
        if (rxBit == '0 && rxLine) rxActive <= 1'b0;   // glitch, not a start bit
        else if (rxBit == RX_LAST) rxActive <= 1'b0;
        else rxBit <= rxBit + 1'b1;
      end else begin
        rxCnt <= rxCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cardLinkDatapath.sv
module cardLinkDatapath
  import cardLinkPkg::*;
#(
  parameter int DIV_W = 8,
  parameter int PRE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  divN,
  input  logic [PRE_W-1:0]  preSel,
  input  logic              clkOutEn,
  input  logic              msbFirst,
  input  logic              invertData,
  input  logic              oddParity,
  input  logic [DATA_W-1:0] txByte,
  input  linkStrobes_t      strobes,
  input  logic              dataIn,
  output logic              cardRise,
  output logic              rxLine,
  output logic              rxFall,
  output logic              cardClk,
  output logic              dataOut,
  output logic [DATA_W-1:0] rxByte,
  output logic              rxValid,
  output logic              rxParityErr,
  output logic              convValid,
  output logic              convInverse
);
  localparam int LIM_W   = DIV_W + 1 + 2 * ((1 << PRE_W) - 1);
  localparam int FRAME_W = DATA_W + 3;

  // clock generator
  logic [DIV_W-1:0] divQ;
  logic [PRE_W-1:0] preQ;
  logic [LIM_W-1:0] limit, preCnt;
  logic             clkReg, tick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divQ <= '0;
      preQ <= '0;
    end else if (strobes.cfgLoad) begin
      divQ <= divN;
      preQ <= preSel;
    end
  end

  always_comb begin
    limit    = ((LIM_W'(divQ) + LIM_W'(1)) << {preQ, 1'b0}) - LIM_W'(1);
    tick     = (preCnt >= limit);
    cardRise = tick && !clkReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      clkReg <= 1'b0;
    end else if (tick) begin
      preCnt <= '0;
      clkReg <= ~clkReg;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  assign cardClk = clkReg & clkOutEn;

  // transmit frame
  logic [FRAME_W-1:0] frame;
  logic [DATA_W-1:0]  txLine;
  logic               txPar;

  always_comb begin
    for (int i = 0; i < DATA_W; i++)
      txLine[i] = (msbFirst ? txByte[DATA_W-1-i] : txByte[i]) ^ invertData;
    txPar = (^txByte) ^ oddParity;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) frame <= '1;
    else if (strobes.txLoad) frame <= {1'b1, txPar, txLine, 1'b0};
    else if (strobes.txShift) frame <= {1'b1, frame[FRAME_W-1:1]};
  end

  assign dataOut = frame[0];

  // receive synchroniser and edge detect
  logic [2:0] syncQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else syncQ <= {syncQ[1:0], dataIn};
  end
  assign rxLine = syncQ[1];
  assign rxFall = syncQ[2] && !syncQ[1];

  // receive shift and decode
  logic [DATA_W:0]   rxShift, rxNext;
  logic [DATA_W-1:0] rxDecoded;
  logic              rxParBad;

  always_comb begin
    rxNext = {rxLine, rxShift[DATA_W:1]};
    for (int i = 0; i < DATA_W; i++)
      rxDecoded[msbFirst ? DATA_W-1-i : i] = rxNext[i] ^ invertData;
    rxParBad = rxNext[DATA_W] != ((^rxDecoded) ^ oddParity);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift     <= '1;
      rxByte      <= '0;
      rxValid     <= 1'b0;
      rxParityErr <= 1'b0;
      convValid   <= 1'b0;
      convInverse <= 1'b0;
    end else begin
      rxValid <= strobes.rxDone;
      if (strobes.rxSample) rxShift <= rxNext;
      if (strobes.rxDone) begin
        rxByte      <= rxDecoded;
        rxParityErr <= rxParBad;
        if (rxNext[DATA_W-1:0] == INIT_DIRECT_LINE) begin
          convValid   <= 1'b1;
          convInverse <= 1'b0;
        end else if (rxNext[DATA_W-1:0] == INIT_INVERSE_LINE) begin
          convValid   <= 1'b1;
          convInverse <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cardCharLink.sv
module cardCharLink
  import cardLinkPkg::*;
#(
  parameter int DIV_W = 8,
  parameter int PRE_W = 2,
  parameter int ETU   = 372
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  divN,
  input  logic [PRE_W-1:0]  preSel,
  input  logic              clkOutEn,
  input  logic              msbFirst,
  input  logic              invertData,
  input  logic              oddParity,
  input  logic [DATA_W-1:0] txByte,
  input  logic              txValid,
  output logic              txBusy,
  output logic [DATA_W-1:0] rxByte,
  output logic              rxValid,
  output logic              rxParityErr,
  output logic              cardClk,
  output logic              dataOut,
  input  logic              dataIn,
  output logic              convValid,
  output logic              convInverse
);
  linkStrobes_t strobes;
  logic cardRise, rxLine, rxFall;

  cardLinkCtrl #(.ETU(ETU)) ctrl (
    .clk(clk), .rstN(rstN), .txValid(txValid), .cardRise(cardRise),
    .rxLine(rxLine), .rxFall(rxFall), .strobes(strobes), .txBusy(txBusy)
  );

  cardLinkDatapath #(.DIV_W(DIV_W), .PRE_W(PRE_W)) dp (
    .clk(clk), .rstN(rstN), .divN(divN), .preSel(preSel), .clkOutEn(clkOutEn),
    .msbFirst(msbFirst), .invertData(invertData), .oddParity(oddParity),
    .txByte(txByte), .strobes(strobes), .dataIn(dataIn), .cardRise(cardRise),
    .rxLine(rxLine), .rxFall(rxFall), .cardClk(cardClk), .dataOut(dataOut),
    .rxByte(rxByte), .rxValid(rxValid), .rxParityErr(rxParityErr),
    .convValid(convValid), .convInverse(convInverse)
  );
endmodule

// File: rtl/cardCharLinkChecker.sv
module cardCharLinkChecker (
  input logic clk,
  input logic rstN,
  input logic txValid,
  input logic txBusy,
  input logic dataOut,
  input logic rxValid,
  input logic convValid,
  input logic convInverse
);
  // R3: a frame only starts on a request
  assert_busy_on_request_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txBusy) |-> $past(txValid));

  // R3: the line is released high while no frame is sent
  assert_idle_line_high_R3: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> dataOut);

  // R3: busy ends after a high guard slot
  assert_guard_before_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txBusy) |-> (dataOut && $past(dataOut)));

  // R7: the receive result is a single-cycle pulse
  assert_rx_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R10: convention flags move only with a received character
  assert_conv_inverse_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(convInverse) |-> rxValid);
  assert_conv_valid_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(convValid) |-> rxValid);
endmodule

bind cardCharLink cardCharLinkChecker chk (
  .clk(clk), .rstN(rstN), .txValid(txValid), .txBusy(txBusy), .dataOut(dataOut),
  .rxValid(rxValid), .convValid(convValid), .convInverse(convInverse)
);

// File: tb/cardCharLink_test.sv
`timescale 1ns/1ps
module cardCharLink_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] divN = '0;
  logic [1:0] preSel = '0;
  logic clkOutEn = 1'b1, msbFirst = 1'b0, invertData = 1'b0, oddParity = 1'b0;
  logic [7:0] txByte = '0;
  logic txValid = 1'b0;
  logic txBusy, rxValid, rxParityErr, cardClk, dataOut, convValid, convInverse;
  logic [7:0] rxByte;
  logic loopMode = 1'b1, bbLevel = 1'b1;
  logic dataIn;

  int checks = 0, errors = 0, rxCount = 0;
  logic [7:0] lastByte = '0;
  logic lastErr = 1'b0;
  bit finished = 0;

  localparam int SLOT = 744;   // module clocks per slot at N=0, n=0

  assign dataIn = loopMode ? dataOut : bbLevel;

  always #2 clk = ~clk;

  cardCharLink uut (
    .clk(clk), .rstN(rstN), .divN(divN), .preSel(preSel), .clkOutEn(clkOutEn),
    .msbFirst(msbFirst), .invertData(invertData), .oddParity(oddParity),
    .txByte(txByte), .txValid(txValid), .txBusy(txBusy), .rxByte(rxByte),
    .rxValid(rxValid), .rxParityErr(rxParityErr), .cardClk(cardClk),
    .dataOut(dataOut), .dataIn(dataIn), .convValid(convValid), .convInverse(convInverse)
  );

  always @(negedge clk) if (rxValid) begin
    rxCount++;
    lastByte = rxByte;
    lastErr = rxParityErr;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [10:0] slots(input logic [7:0] b, input logic m, input logic v, input logic o);
    logic [10:0] s;
    s[0] = 1'b0;
    for (int i = 0; i < 8; i++) s[i+1] = (m ? b[7-i] : b[i]) ^ v;
    s[9] = (^b) ^ o;
    s[10] = 1'b1;
    return s;
  endfunction

  task automatic waitRise(output int n);
    logic p;
    n = 0;
    p = cardClk;
    @(negedge clk); n = 1;
    while (!(cardClk && !p) && n < 5000) begin
      p = cardClk;
      @(negedge clk); n++;
    end
  endtask

  task automatic measure(output int per);
    int d;
    waitRise(d);
    waitRise(d);
    waitRise(per);
  endtask

  task automatic sendCheck(input logic [7:0] b, input logic m, input logic v, input logic o, input bit poke);
    logic [10:0] e;
    int startCnt;
    @(negedge clk);
    msbFirst = m; invertData = v; oddParity = o; txByte = b; loopMode = 1'b1;
    e = slots(b, m, v, o);
    startCnt = rxCount;
    repeat (2) @(negedge clk);
    txValid = 1'b1;
    @(negedge clk);
    txValid = 1'b0;
    check("R3 busy after request", txBusy, 1);
    for (int k = 0; k < 11; k++) begin
      repeat ((k == 0) ? 371 : SLOT) @(negedge clk);
      check($sformatf("R3/R4/R5/R6 slot %0d of %02h", k, b), dataOut, e[k]);
      if (k == 8) check("R7 no result before parity", rxCount, startCnt);
      if (poke && k == 3) begin
        txByte = ~b; txValid = 1'b1;
        @(negedge clk);
        txValid = 1'b0; txByte = b;
      end
    end
    check("R3 busy in guard", txBusy, 1);
    repeat (400) @(negedge clk);
    check("R3 idle after guard", txBusy, 0);
    check("R11 line idle after frame", dataOut, 1);
    check("R7 one result", rxCount, startCnt + 1);
    check($sformatf("R7 byte %02h", b), lastByte, b);
    check("R8 no parity error", lastErr, 0);
  endtask

  task automatic bangFrame(input logic [10:0] s);
    loopMode = 1'b0;
    for (int k = 0; k < 10; k++) begin
      bbLevel = s[k];
      repeat (SLOT) @(negedge clk);
    end
    bbLevel = 1'b1;
    repeat (800) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int per, cnt, c0;
    logic [10:0] s;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R3 reset line high", dataOut, 1);
    check("R3 reset not busy", txBusy, 0);
    check("R7 reset no result", rxValid, 0);
    check("R10 reset no convention", convValid, 0);

    // R1: period sweep
    for (int t = 0; t < 7; t++) begin
      logic [7:0] nv; logic [1:0] pv;
      nv = (t == 1) ? 8'd3 : (t == 3) ? 8'd2 : (t == 4 || t == 6) ? 8'd1 : 8'd0;
      pv = (t < 2) ? 2'd0 : (t < 4) ? 2'd1 : (t == 4) ? 2'd2 : 2'd3;
      divN = nv; preSel = pv;
      measure(per);
      check($sformatf("R1 period n=%0d N=%0d", pv, nv), per, 2 * (4 ** pv) * (nv + 1));
    end
    clkOutEn = 1'b0;
    cnt = 0;
    repeat (300) begin @(negedge clk); if (cardClk) cnt++; end
    check("R1 clock held low", cnt, 0);
    clkOutEn = 1'b1;
    divN = 0; preSel = 0;
    repeat (600) @(negedge clk);

    // R2: divider change during a frame
    c0 = rxCount;
    txByte = 8'h55; txValid = 1'b1;
    @(negedge clk); txValid = 1'b0;
    repeat (10) @(negedge clk);
    divN = 8'd5;
    measure(per);
    check("R2 period kept while busy", per, 2);
    cnt = 0;
    while (txBusy && cnt < 20000) begin @(negedge clk); cnt++; end
    repeat (5) @(negedge clk);
    measure(per);
    check("R2 period applied when idle", per, 12);
    check("R7 loopback byte 55", lastByte, 8'h55);
    check("R7 loopback count", rxCount, c0 + 1);
    divN = 0;
    repeat (100) @(negedge clk);

    // transmit/receive sweep over the control combinations
    sendCheck(8'hA5, 0, 0, 0, 0);
    sendCheck(8'h3C, 1, 0, 0, 1);
    sendCheck(8'h81, 0, 1, 0, 0);
    sendCheck(8'h6E, 1, 1, 1, 0);
    sendCheck(8'h00, 0, 0, 1, 0);
    check("R10 no convention after plain bytes", convValid, 0);
    sendCheck(8'h3B, 0, 0, 0, 0);
    check("R10 direct seen", convValid, 1);
    check("R10 direct kind", convInverse, 0);
    sendCheck(8'hFF, 1, 1, 0, 0);
    check("R10 unchanged by other byte", convValid, 1);
    sendCheck(8'h3F, 1, 1, 1, 0);
    check("R10 inverse seen", convValid, 1);
    check("R10 inverse kind", convInverse, 1);

    // R8: parity error
    msbFirst = 0; invertData = 0; oddParity = 0;
    c0 = rxCount;
    s = slots(8'h5A, 0, 0, 0);
    s[9] = ~s[9];
    bangFrame(s);
    check("R8 result count", rxCount, c0 + 1);
    check("R8 byte kept", lastByte, 8'h5A);
    check("R8 parity error flagged", lastErr, 1);

    // R9: glitch rejected, next character fine
    loopMode = 1'b0;
    bbLevel = 1'b0;
    repeat (100) @(negedge clk);
    bbLevel = 1'b1;
    repeat (1500) @(negedge clk);
    check("R9 glitch gives no result", rxCount, c0 + 1);
    msbFirst = 1; invertData = 0; oddParity = 1;
    bangFrame(slots(8'hC3, 1, 0, 1));
    check("R9 next count", rxCount, c0 + 2);
    check("R9 next byte", lastByte, 8'hC3);
    check("R8 next parity ok", lastErr, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule